// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block is the digital side of a supply monitor built around two external voltage comparators, one watching the analog rail and one watching the digital rail. Each comparator output is high while its rail is above the selected threshold. The block passes both outputs through a synchronizer and a persistence filter, so that short dips are ignored. When either rail is low, it raises a sticky low-supply flag. The flag clears itself only after both rails have stayed healthy for an unbroken hold-off period. Firmware can then save its state before the supply collapses, and normal execution does not resume until the supply is stable again.

Software reaches the block through a single byte-wide special-function register at address 0xDF on a simple bus. The bus has an address, a write strobe, write data and combinational read data. The register holds the monitor enable, a two-bit threshold select that is passed straight to the analog threshold selector, a live status bit for the digital rail and the interrupt flag. The interrupt request is the flag gated by an external interrupt-enable input.

Top module: `supmon_ctrl`

## Requirements
- R1: Register fields are bit 0 enable, bits 4:3 threshold select, bit 5 flag, bit 6 digital-rail status, and bits 7, 2 and 1 always read 0. Read data is 0x00 at any address other than 0xDF.
- R2: Bit 6 reads 1 while the digital-rail comparator input is high and 0 while it is low, after a two-clock synchronizer delay.
- R3: trip_sel_o always equals register bits 4:3 (00 = highest threshold, 11 = lowest) and changes only on a write to 0xDF.
- R4: While enabled, the flag is set when either filtered comparator reports low.
- R5: A comparator low shorter than FILT_CYC consecutive clocks does not set the flag.
- R6: While enabled with the flag set, the flag clears by itself after both comparators have read high for HOLD_CYC consecutive clocks.
- R7: A filtered low during the hold-off restarts the countdown from zero.
- R8: Writing 1 to bit 5 sets the flag. Writing 0 clears it only while neither filtered comparator reports low.
- R9: While disabled, the flag is neither set by a low rail nor cleared by the hold-off. It changes only by software write.
- R10: irq_o is high exactly when the flag and int_en_i are both high.
- R11: After reset the register reads 0x00 apart from bit 6. Writes to any other address leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from address |
| cmp_ana_i | input | 1 | Analog-rail comparator, high = above threshold |
| cmp_dig_i | input | 1 | Digital-rail comparator, high = above threshold |
| int_en_i | input | 1 | External interrupt enable |
| trip_sel_o | output | 2 | Threshold select to the analog selector |
| irq_o | output | 1 | Interrupt request |

## Verification
If the filter counter is wrong, the flag appears at the ports either after a dip shorter than FILT_CYC clocks or not at all after a long one. Either case shows within a few clocks of the dip. If the hold-off counter is wrong, or it is not cleared on a fresh low, the flag clears too early or too late. The countdown restart case separates a counter that restarts from one that only pauses, because the flag must still be set well after the first recovery.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam logic [7:0] SFR_ADDR = 8'hDF;
  localparam int BIT_EN   = 0;
  localparam int BIT_SEL0 = 3;
  localparam int BIT_FLAG = 5;
  localparam int BIT_STAT = 6;
  localparam int NCH      = 2;
  localparam int CH_ANA   = 0;
  localparam int CH_DIG   = 1;
endpackage

// File: rtl/supmon_rst_sync.sv
module supmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/supmon_filt.sv
module supmon_filt #(
  parameter int FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_i,
  output logic sync_o,
  output logic low_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic          s1_q, s2_q;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          low_q, low_d;

  always_comb begin
    if (s2_q) begin
      cnt_d = '0;
      low_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      low_d = low_q | (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      s1_q  <= cmp_i;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
      low_q <= low_d;
    end
  end

  assign sync_o = s2_q;
  assign low_o  = low_q;

  // R5: a filtered low only follows a synchronized low sample
  a_r5_low_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_q) |-> $past(!s2_q));
  // R5: counter never passes its limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/supmon_holdoff.sv
module supmon_holdoff #(
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i || cnt_q == LAST) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R7: a stopped countdown restarts from zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
  // R6: count stays inside the hold-off window
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl #(
  parameter int FILT_CYC = 16,
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_we,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       cmp_ana_i,
  input  logic       cmp_dig_i,
  input  logic       int_en_i,
  output logic [1:0] trip_sel_o,
  output logic       irq_o
);
  import supmon_pkg::*;

  logic             rst_s_n;
  logic [NCH-1:0]   cmp_vec;
  logic [NCH-1:0]   sync_vec;
  logic [NCH-1:0]   low_vec;
  logic             any_low;
  logic             wr_hit;
  logic             en_q, en_d;
  logic [1:0]       sel_q, sel_d;
  logic             flag_q, flag_d;
  logic             run;
  logic             done;

  supmon_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_s_n)
  );

  assign cmp_vec[CH_ANA] = cmp_ana_i;
  assign cmp_vec[CH_DIG] = cmp_dig_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    supmon_filt #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .cmp_i  (cmp_vec[g]),
      .sync_o (sync_vec[g]),
      .low_o  (low_vec[g])
    );
  end

  assign any_low = |low_vec;
  assign wr_hit  = sfr_we && (sfr_addr == SFR_ADDR);
  assign run     = en_q && flag_q && !any_low;

  supmon_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run_i  (run),
    .done_o (done)
  );

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    flag_d = flag_q;
    if (wr_hit) begin
      en_d  = sfr_wdata[BIT_EN];
      sel_d = sfr_wdata[BIT_SEL0 +: 2];
    end
    if (en_q && any_low) begin
      flag_d = 1'b1;
    end else if (wr_hit && (sfr_wdata[BIT_FLAG] || !any_low)) begin
      flag_d = sfr_wdata[BIT_FLAG];
    end else if (done) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q   <= 1'b0;
      sel_q  <= 2'b00;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == SFR_ADDR) begin
      sfr_rdata[BIT_EN]          = en_q;
      sfr_rdata[BIT_SEL0 +: 2]   = sel_q;
      sfr_rdata[BIT_FLAG]        = flag_q;
      sfr_rdata[BIT_STAT]        = sync_vec[CH_DIG];
    end
  end

  assign trip_sel_o = sel_q;
  assign irq_o      = flag_q & int_en_i;

  // R4: enabled low rail sets the flag
  a_r4_low_sets: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en_q && any_low) |=> flag_q);
  // R8: no clearing while a rail is low
  a_r8_hold_while_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    (any_low && flag_q) |=> flag_q);
  // R9: disabled flag moves only on a write
  a_r9_disabled_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!en_q && !wr_hit) |=> $stable(flag_q));
  // R3: threshold select changes only on a write
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_hit |=> $stable(trip_sel_o));
  // R6: auto-clear happens only after a full hold-off
  a_r6_clear_after_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_q && !wr_hit && !done) |=> flag_q);
endmodule

// File: tb/supmon_ctrl_tb.sv
module supmon_ctrl_tb_top;
  localparam int FILT = 4;
  localparam int HOLD = 50;
  localparam logic [7:0] ADDR = 8'hDF;
  // {write data, expected read data}
  localparam logic [15:0] VEC [6] = '{
    16'h19_59, 16'hFF_79, 16'h00_40, 16'h08_48, 16'h26_60, 16'h00_40
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] sfr_addr;
  logic sfr_we;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic cmp_ana, cmp_dig, int_en;
  logic [1:0] trip_sel;
  logic irq;
  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  supmon_ctrl #(.FILT_CYC(FILT), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cmp_ana_i(cmp_ana),
    .cmp_dig_i(cmp_dig), .int_en_i(int_en), .trip_sel_o(trip_sel), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0; sfr_addr = ADDR;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
    sfr_addr = ADDR;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sfr_addr = ADDR; sfr_we = 1'b0; sfr_wdata = 8'h00;
    cmp_ana = 1'b1; cmp_dig = 1'b1; int_en = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    rdreg(ADDR, rd); chk("R11 reset value", rd, 8'h40);
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < 6; i++) begin
      wr(ADDR, VEC[i][15:8]);
      rdreg(ADDR, rd); chk("R1 field readback", rd, VEC[i][7:0]);
      chk("R3 trip select", {6'd0, trip_sel}, {6'd0, VEC[i][4:3]});
    end

    rdreg(8'h00, rd); chk("R1 other address reads zero", rd, 8'h00);
    wr(8'hDE, 8'hFF);
    rdreg(ADDR, rd); chk("R11 foreign write ignored", rd, 8'h40);

    // R5 short dip while enabled
    wr(ADDR, 8'h01);
    cmp_dig = 1'b0; cyc(FILT - 1); cmp_dig = 1'b1;
    cyc(20);
    rdreg(ADDR, rd); chk("R5 glitch ignored", rd, 8'h41);

    // R2/R4 long low
    cmp_dig = 1'b0; cyc(FILT + 6);
    rdreg(ADDR, rd); chk("R2 R4 status low and flag set", rd, 8'h21);
    chk("R10 irq masked", {7'd0, irq}, 8'h00);
    int_en = 1'b1; #1;
    chk("R10 irq raised", {7'd0, irq}, 8'h01);

    // R8 clear blocked while low
    wr(ADDR, 8'h01);
    rdreg(ADDR, rd); chk("R8 clear blocked while low", rd, 8'h21);

    // R6 hold-off
    cmp_dig = 1'b1;
    cyc(HOLD - 10);
    rdreg(ADDR, rd); chk("R6 flag held during hold-off", rd, 8'h61);
    cyc(30);
    rdreg(ADDR, rd); chk("R6 flag auto-cleared", rd, 8'h41);
    chk("R10 irq dropped", {7'd0, irq}, 8'h00);

    // R7 restart on analog low during countdown
    cmp_ana = 1'b0; cyc(FILT + 6); cmp_ana = 1'b1;
    cyc(30);
    cmp_ana = 1'b0; cyc(FILT + 4); cmp_ana = 1'b1;
    cyc(40);
    rdreg(ADDR, rd); chk("R7 countdown restarted", rd, 8'h61);
    cyc(30);
    rdreg(ADDR, rd); chk("R7 clears after full hold-off", rd, 8'h41);

    // R8 software set and clear with rails healthy
    wr(ADDR, 8'h21);
    rdreg(ADDR, rd); chk("R8 software set", rd, 8'h61);
    wr(ADDR, 8'h01);
    rdreg(ADDR, rd); chk("R8 software clear", rd, 8'h41);

    // R9 disabled
    wr(ADDR, 8'h00);
    cmp_ana = 1'b0; cyc(FILT + 10);
    rdreg(ADDR, rd); chk("R9 no set while disabled", rd, 8'h40);
    cmp_ana = 1'b1;
    wr(ADDR, 8'h20);
    cyc(HOLD + 30);
    rdreg(ADDR, rd); chk("R9 no auto-clear while disabled", rd, 8'h60);
    wr(ADDR, 8'h00);
    rdreg(ADDR, rd); chk("R9 software clear while disabled", rd, 8'h40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule